// File: doc/BRIEF.md
# Programmable Pulse Generator

This block turns a free-running count-clock enable into a periodic rectangular wave. An up-counter advances once per enabled count clock and restarts from zero after it meets the period register, so each cycle of the output spans the period setting plus one count clocks. The output starts each cycle at its active (high) level. When the counter meets the duty register, the output flips to low, provided the inversion-enable input is set. That meeting also raises a sticky interrupt request flag, which a mask input can hide from the interrupt line.

The control is a small state machine with three states. `ST_STOP` means halted: the counter is held at zero and the output is low. `ST_RUN` means counting normally. `ST_SETTLE` is a guard state entered after a duty write while running. The transitions are named as follows:
- *start* (`ST_STOP` to `ST_RUN`) when the run input rises.
- *rewrite* (`ST_RUN` to `ST_SETTLE`) on a duty write.
- *settled* (`ST_SETTLE` to `ST_RUN`) after one enabled count clock with no further duty write.
- *halt* (any state to `ST_STOP`) when run falls.

While in `ST_SETTLE`, a duty match neither flips the output nor sets the flag. This lets software rewrite the duty while running, wait one count clock, and then re-enable the output flip and the interrupt without a spurious edge.

Top module: `ppg16_top`

## Requirements
- R1: With run high and valid settings, the output repeats every (period + 1) enabled count clocks. On the enabled count clock where the counter equals the period register, the counter returns to 0 and the output is driven high.
- R2: With inversion enabled, the output is high for exactly (duty + 1) enabled count clocks per cycle and low for the rest.
- R3: `cfg_err` is 1 exactly when the duty register is not strictly less than the period register (this includes period = 0).
- R4: With `inv_en` low, a duty match leaves the output unchanged, so the output stays high for the whole cycle.
- R5: A duty match on an enabled count clock in `ST_RUN` sets `irq_flag`. The flag stays set until `flag_clr` is applied. A clear in the same clock as a new match leaves it set.
- R6: `irq_out` equals `irq_flag` while `irq_mask` is 0 and is 0 while `irq_mask` is 1. The mask never alters `irq_flag`.
- R7: Lowering run clears the counter and drives the output low on the next clock. Raising run drives the output high on the next clock, and the counter starts from 0.
- R8: The counter and output advance only on clocks where `tick_en` is 1. Other clocks hold them.
- R9: A duty write while running enters `ST_SETTLE`. Duty matches are ignored (no output flip, no flag) until one enabled count clock has passed without a further duty write. After that, the new duty value takes effect.
- R10: After reset the period register is all ones and the duty register is 0. The output, flag and interrupt are low, and `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count-clock enable |
| run | input | 1 | 1 = run, 0 = stop |
| period_we | input | 1 | Period register write strobe |
| period_wdata | input | CNT_W | New period value |
| duty_we | input | 1 | Duty register write strobe |
| duty_wdata | input | CNT_W | New duty value |
| inv_en | input | 1 | Allow a duty match to flip the output |
| flag_clr | input | 1 | Clear the interrupt request flag |
| irq_mask | input | 1 | 1 hides the flag from `irq_out` |
| pulse_out | output | 1 | Pulse output, active high |
| irq_flag | output | 1 | Sticky duty-match request flag |
| irq_out | output | 1 | Masked interrupt |
| cfg_err | output | 1 | Illegal period/duty combination |

## Verification
The assertions take for granted that run is the only way to stop the block and that software performs register writes between clock edges. They do not assume that duty is below period. For that reason, the restart and stability properties guard themselves on the period match rather than on a legal configuration. The stimulus keeps duty strictly below period in every running scenario and writes registers only while stopped, with one exception: a deliberate duty rewrite that exercises the guard state. Illegal combinations are applied only while stopped, during the configuration-error sweep. A 4-bit counter width makes it possible to sweep every legal period/duty pair.

// File: rtl/ppg16_pkg.sv
package ppg16_pkg;
    typedef enum logic [1:0] {
        ST_STOP   = 2'd0,
        ST_RUN    = 2'd1,
        ST_SETTLE = 2'd2
    } ppg_state_e;
endpackage

// File: rtl/ppg16_counter.sv
module ppg16_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    // wrap marks the enabled count clock on which the counter meets its limit
    assign wrap = adv && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= wrap ? '0 : cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ppg16_ctrl.sv
module ppg16_ctrl
    import ppg16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       duty_we,
    input  logic       duty_hit,
    input  logic       wrap,
    input  logic       inv_en,
    output ppg_state_e state_q,
    output logic       pulse_q,
    output logic       hit_evt
);
    ppg_state_e state_d;

    // a duty match counts only in ST_RUN, on an enabled clock, outside a rewrite
    assign hit_evt = run && tick && (state_q == ST_RUN) && !duty_we && duty_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:   if (run) state_d = ST_RUN;
            ST_RUN: begin
                if (!run)         state_d = ST_STOP;
                else if (duty_we) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (!run)                 state_d = ST_STOP;
                else if (tick && !duty_we) state_d = ST_RUN;
            end
            default:   state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_STOP: pulse_q <= run;
                ST_RUN, ST_SETTLE: begin
                    if (!run)                   pulse_q <= 1'b0;
                    else if (wrap)              pulse_q <= 1'b1;
                    else if (hit_evt && inv_en) pulse_q <= ~pulse_q;
                end
                default: pulse_q <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ppg16_flag.sv
module ppg16_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic mask,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= set | (flag & ~clr);
    end

    assign irq = flag & ~mask;
endmodule

// File: rtl/ppg16_top.sv
module ppg16_top
    import ppg16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run,
    input  logic             period_we,
    input  logic [CNT_W-1:0] period_wdata,
    input  logic             duty_we,
    input  logic [CNT_W-1:0] duty_wdata,
    input  logic             inv_en,
    input  logic             flag_clr,
    input  logic             irq_mask,
    output logic             pulse_out,
    output logic             irq_flag,
    output logic             irq_out,
    output logic             cfg_err
);
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] duty_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    logic             hit_evt;
    logic             cnt_adv;
    ppg_state_e       state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '1;
            duty_q   <= '0;
        end else begin
            if (period_we) period_q <= period_wdata;
            if (duty_we)   duty_q   <= duty_wdata;
        end
    end

    assign cfg_err = !(duty_q < period_q);
    assign cnt_adv = tick_en && run && (state_q != ST_STOP);

    ppg16_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!run),
        .adv   (cnt_adv),
        .limit (period_q),
        .cnt   (cnt_q),
        .wrap  (wrap)
    );

    ppg16_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick_en),
        .duty_we  (duty_we),
        .duty_hit (cnt_q == duty_q),
        .wrap     (wrap),
        .inv_en   (inv_en),
        .state_q  (state_q),
        .pulse_q  (pulse_out),
        .hit_evt  (hit_evt)
    );

    ppg16_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (hit_evt),
        .clr   (flag_clr),
        .mask  (irq_mask),
        .flag  (irq_flag),
        .irq   (irq_out)
    );
endmodule

// File: rtl/ppg16_checker.sv
module ppg16_checker
    import ppg16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             tick_en,
    input logic             inv_en,
    input logic             duty_we,
    input logic             flag_clr,
    input logic             irq_mask,
    input logic             pulse_out,
    input logic             irq_flag,
    input logic             irq_out,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] period_q,
    input logic [CNT_W-1:0] duty_q,
    input ppg_state_e       state_q
);
    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!pulse_out && cnt_q == '0)); // R7

    AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state_q != ST_STOP && tick_en && cnt_q == period_q) |=> (pulse_out && cnt_q == '0)); // R1

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick_en) |=> $stable(cnt_q)); // R8

    AST_NO_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state_q != ST_STOP && !inv_en && !(tick_en && cnt_q == period_q)) |=> $stable(pulse_out)); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && state_q == ST_RUN && tick_en && !duty_we && cnt_q == duty_q) |=> irq_flag); // R5

    AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && !irq_flag) |=> !irq_flag); // R9

    AST_MASK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq_out); // R6
endmodule

bind ppg16_top ppg16_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick_en   (tick_en),
    .inv_en    (inv_en),
    .duty_we   (duty_we),
    .flag_clr  (flag_clr),
    .irq_mask  (irq_mask),
    .pulse_out (pulse_out),
    .irq_flag  (irq_flag),
    .irq_out   (irq_out),
    .cnt_q     (cnt_q),
    .period_q  (period_q),
    .duty_q    (duty_q),
    .state_q   (state_q)
);

// File: tb/test_ppg16_top.sv
`timescale 1ns/1ps
module test_ppg16_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         tick_en, run, period_we, duty_we, inv_en, flag_clr, irq_mask;
    logic [W-1:0] period_wdata, duty_wdata;
    logic         pulse_out, irq_flag, irq_out, cfg_err;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ppg16_top #(.CNT_W(W)) i_ppg16_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .run          (run),
        .period_we    (period_we),
        .period_wdata (period_wdata),
        .duty_we      (duty_we),
        .duty_wdata   (duty_wdata),
        .inv_en       (inv_en),
        .flag_clr     (flag_clr),
        .irq_mask     (irq_mask),
        .pulse_out    (pulse_out),
        .irq_flag     (irq_flag),
        .irq_out      (irq_out),
        .cfg_err      (cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // stopped: load registers and clear the flag in one clock
    task automatic load(input int p, input int d);
        run          = 1'b0;
        period_we    = 1'b1;
        duty_we      = 1'b1;
        period_wdata = W'(p);
        duty_wdata   = W'(d);
        flag_clr     = 1'b1;
        @(negedge clk);
        period_we = 1'b0;
        duty_we   = 1'b0;
        flag_clr  = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; tick_en = 1'b1; run = 1'b0; period_we = 1'b0; duty_we = 1'b0;
        inv_en = 1'b1; flag_clr = 1'b0; irq_mask = 1'b0;
        period_wdata = '0; duty_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 pulse", int'(pulse_out), 0);
        chk("R10 flag", int'(irq_flag), 0);
        chk("R10 irq", int'(irq_out), 0);
        chk("R10 cfg_err", int'(cfg_err), 0);

        // R3: every period/duty pair
        for (int p = 0; p < 16; p++) begin
            for (int d = 0; d < 16; d++) begin
                load(p, d);
                chk("R3 cfg_err", int'(cfg_err), (d >= p) ? 1 : 0);
            end
        end

        // R1/R2/R7: every legal pair, two cycles each
        inv_en = 1'b1;
        for (int p = 1; p < 16; p++) begin
            for (int d = 0; d < p; d++) begin
                load(p, d);
                run = 1'b1;
                @(negedge clk);
                for (int k = 0; k < 2 * (p + 1); k++) begin
                    if (k == 0) chk("R7 start high", int'(pulse_out), 1);
                    chk("R1 R2 pulse", int'(pulse_out), ((k % (p + 1)) <= d) ? 1 : 0);
                    chk("R5 flag", int'(irq_flag), (k > d) ? 1 : 0);
                    @(negedge clk);
                end
                run = 1'b0;
                @(negedge clk);
                chk("R7 stop low", int'(pulse_out), 0);
            end
        end

        // R8: gated count clock
        begin
            int m;
            load(5, 2);
            run = 1'b1;
            @(negedge clk);
            m = 0;
            chk("R8 pulse", int'(pulse_out), 1);
            for (int k = 1; k <= 40; k++) begin
                tick_en = (k % 3 != 1);
                @(negedge clk);
                if (tick_en) m++;
                chk("R8 pulse", int'(pulse_out), ((m % 6) <= 2) ? 1 : 0);
            end
            tick_en = 1'b1;
        end

        // R4: inversion disabled
        load(4, 1);
        inv_en = 1'b0;
        run = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 15; k++) begin
            chk("R4 pulse held", int'(pulse_out), 1);
            chk("R5 flag without inversion", int'(irq_flag), (k > 1) ? 1 : 0);
            @(negedge clk);
        end
        inv_en = 1'b1;

        // R5/R6: set wins over clear, sticky, mask
        load(5, 2);
        run = 1'b1;
        @(negedge clk);             // k=0
        @(negedge clk);             // k=1
        @(negedge clk);             // k=2
        chk("R5 flag before match", int'(irq_flag), 0);
        flag_clr = 1'b1;            // clear on the match clock (edge k=3)
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R5 set wins", int'(irq_flag), 1);
        @(negedge clk);
        chk("R5 sticky", int'(irq_flag), 1);
        irq_mask = 1'b1;
        #1;
        chk("R6 masked irq", int'(irq_out), 0);
        chk("R6 flag kept", int'(irq_flag), 1);
        irq_mask = 1'b0;
        #1;
        chk("R6 unmasked irq", int'(irq_out), 1);
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R5 cleared", int'(irq_flag), 0);

        // R9: duty rewrite while running
        load(7, 5);
        run = 1'b1;
        @(negedge clk);             // k=0
        @(negedge clk);             // k=1
        @(negedge clk);             // k=2
        duty_we = 1'b1;
        duty_wdata = W'(3);
        for (int k = 3; k <= 12; k++) begin
            @(negedge clk);
            duty_we = 1'b0;
            if (k < 12) begin
                chk("R9 pulse held in guard", int'(pulse_out), 1);
                chk("R9 no flag in guard", int'(irq_flag), 0);
            end else begin
                chk("R9 new duty pulse", int'(pulse_out), 0);
                chk("R9 new duty flag", int'(irq_flag), 1);
            end
        end
        run = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule